// File: doc/BRIEF.md
# Serial SAR Converter Read-After-Conversion Controller

This block is the host side of the serial link to one or more 16-bit successive-approximation converters. When the core asks for a sample, the block drops the read/convert strobe for a fixed number of system clocks. It then watches the converter's busy line fall and rise again. Only once busy is back high does it run a burst of serial clock pulses, produced by dividing the system clock. It shifts in the result, most significant bit first, and hands each 16-bit word to the core with the index of the device that produced it.

Several converters can share the data line in a chain. The controller keeps clocking for 16 pulses per device, so the words of the devices further up the chain follow the first one. The receive edge is chosen per conversion. In rising-edge capture the controller issues one extra pulse, because the first bit is not valid until after the first falling edge. In falling-edge capture the pulse count is a whole number of words. A watchdog raises an error flag if busy never comes back high. Chip select is held low permanently.

Top module: `sar_read_ctrl`

## Requirements
- R1: After reset, `conv_n_o` is high and `sclk_o`, `done_o`, `err_o` and `word_valid_o` are low. `idle_o` is high, and `cs_n_o` is low at all times.
- R2: A `start_i` seen while idle drives `conv_n_o` low for exactly CONV_LOW system clocks, then releases it.
- R3: `sclk_o` stays low from the start until `busy_i` has been seen low and then high again. No rising edge of `sclk_o` occurs while `busy_i` is low.
- R4: A burst has 16*DEVICES+1 pulses when `rise_mode_i` was 1 at the start, and 16*DEVICES pulses when it was 0. Each pulse is high for HALF_DIV system clocks and low for HALF_DIV system clocks.
- R5: With `rise_mode_i`=1, data is taken on rising edges 2 through 16*DEVICES+1, most significant bit first.
- R6: With `rise_mode_i`=0, data is taken on falling edges 1 through 16*DEVICES, most significant bit first.
- R7: Each completed word appears on `word_o` with `word_valid_o` high for one system clock. `word_idx_o` counts 0 to DEVICES-1 in arrival order, and index 0 is the first word shifted in.
- R8: `done_o` is high for exactly one system clock per burst, after the last pulse has ended with `sclk_o` low.
- R9: `start_i` has no effect unless the controller is idle: no second low pulse appears on `conv_n_o`.
- R10: If `busy_i` is not back high TIMEOUT system clocks after `conv_n_o` fell, `err_o` rises at that point and the controller returns to idle with no clock burst. `err_o` clears when the next start is accepted.
- R11: `rise_mode_i` is registered when a start is accepted, and changing it during a conversion or burst does not alter that burst's pulse count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a conversion and read |
| rise_mode_i | input | 1 | 1: capture on sclk rising edges, 0: on falling edges |
| busy_i | input | 1 | Converter busy line, low during conversion |
| sdata_i | input | 1 | Serial data from the converter chain |
| conv_n_o | output | 1 | Read/convert strobe, low pulse starts a conversion |
| cs_n_o | output | 1 | Chip select, held low |
| sclk_o | output | 1 | Discontinuous serial clock |
| word_o | output | WORD_W | Received word |
| word_idx_o | output | max(1,clog2(DEVICES)) | Chain position of `word_o` |
| word_valid_o | output | 1 | `word_o` valid this cycle |
| done_o | output | 1 | Burst finished |
| err_o | output | 1 | Busy timeout |
| idle_o | output | 1 | Controller idle, ready for a start |

## Verification
The bench feeds a converter model that moves its data line shortly after each serial rising edge. A controller that sampled rising edges starting from the first pulse would return every word shifted by one bit. If it used the wrong pulse count, the last word would come back short or carry tag bits. The model lets busy fall and rise, or hold it low for the timeout case. Any pulse seen while busy is low shows a controller that clocks during conversion, and an error flag that comes a cycle off shows a counter that is off by one. Repeated starts and a mode flip during a burst expose a design that restarts or changes its pulse count partway through.

// File: rtl/sar_rd_pkg.sv
// Shared types for the serial converter read controller.
package sar_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WLO,
        ST_WHI,
        ST_SHIFT
    } rd_state_t;
endpackage

// File: rtl/sar_sclk_div.sv
// Serial clock divider: while run_i is high, toggles sclk every HALF_DIV
// system clocks, starting low. Flags the system-clock edge on which sclk
// rises or falls. Assumes run_i drops on the edge of the final fall.
module sar_sclk_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          sclk_q;
    logic          last;

    assign last   = (cnt == CW'(HALF_DIV - 1));
    assign rise_o = run_i && last && !sclk_q;
    assign fall_o = run_i && last && sclk_q;
    assign sclk_o = sclk_q;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (last) begin
            cnt    <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    sclk_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !sclk_o);
endmodule

// File: rtl/sar_word_cap.sv
// Word assembler: shifts one bit per sample strobe, MSB first, and emits
// a word with its chain index each WORD_W samples. clr_i restarts the
// bit and word counters. Assumes strobes are at least two clocks apart.
module sar_word_cap #(
    parameter int WORD_W  = 16,
    parameter int DEVICES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              smp_i,
    input  logic              sdata_i,
    output logic [WORD_W-1:0] word_o,
    output logic [((DEVICES > 1) ? $clog2(DEVICES) : 1)-1:0] idx_o,
    output logic              valid_o
);
    localparam int BW = $clog2(WORD_W);
    localparam int IW = (DEVICES > 1) ? $clog2(DEVICES) : 1;

    logic [WORD_W-2:0] sh;
    logic [BW-1:0]     bcnt;
    logic [IW-1:0]     widx;

    // Shift register, bit counter and word hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            bcnt    <= '0;
            widx    <= '0;
            word_o  <= '0;
            idx_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (clr_i) begin
                bcnt <= '0;
                widx <= '0;
            end else if (smp_i) begin
                sh <= {sh[WORD_W-3:0], sdata_i};
                if (bcnt == BW'(WORD_W - 1)) begin
                    bcnt    <= '0;
                    word_o  <= {sh, sdata_i};
                    idx_o   <= widx;
                    valid_o <= 1'b1;
                    widx    <= widx + 1'b1;
                end else begin
                    bcnt <= bcnt + 1'b1;
                end
            end
        end
    end

    // R7
    word_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ({1'b0, idx_o} < (IW+1)'(DEVICES)));
    // R7
    word_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
endmodule

// File: rtl/sar_read_ctrl.sv
// Read-after-conversion controller: start pulse on conv_n_o, wait for the
// busy low/high handshake with a timeout, then a burst of divided serial
// clock pulses capturing DEVICES words. Assumes busy_i and sdata_i are
// synchronous to clk and TIMEOUT > CONV_LOW.
module sar_read_ctrl
    import sar_rd_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int DEVICES  = 2,
    parameter int HALF_DIV = 2,
    parameter int CONV_LOW = 2,
    parameter int TIMEOUT  = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rise_mode_i,
    input  logic              busy_i,
    input  logic              sdata_i,
    output logic              conv_n_o,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic [WORD_W-1:0] word_o,
    output logic [((DEVICES > 1) ? $clog2(DEVICES) : 1)-1:0] word_idx_o,
    output logic              word_valid_o,
    output logic              done_o,
    output logic              err_o,
    output logic              idle_o
);
    localparam int PW = $clog2(WORD_W * DEVICES + 2);
    localparam int TW = $clog2(TIMEOUT + 1);

    rd_state_t     state;
    logic [TW-1:0] tcnt;
    logic [PW-1:0] pcnt;
    logic [PW-1:0] total;
    logic          mode_q;
    logic          done_q;
    logic          err_q;
    logic          run;
    logic          rise;
    logic          fall;
    logic          smp;
    logic          accept;
    logic          tmo;

    assign run      = (state == ST_SHIFT);
    assign accept   = (state == ST_IDLE) && start_i;
    assign total    = PW'(WORD_W * DEVICES) + {{(PW-1){1'b0}}, mode_q};
    assign smp      = mode_q ? (rise && (pcnt != '0)) : fall;
    assign tmo      = (tcnt == TW'(TIMEOUT - 1));
    assign conv_n_o = (state != ST_CONV);
    assign cs_n_o   = 1'b0;
    assign done_o   = done_q;
    assign err_o    = err_q;
    assign idle_o   = (state == ST_IDLE);

    sar_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .sclk_o(sclk_o),
        .rise_o(rise),
        .fall_o(fall)
    );

    sar_word_cap #(.WORD_W(WORD_W), .DEVICES(DEVICES)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .smp_i  (smp),
        .sdata_i(sdata_i),
        .word_o (word_o),
        .idx_o  (word_idx_o),
        .valid_o(word_valid_o)
    );

    // Sequencer: start pulse, busy handshake with timeout, clock burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            tcnt   <= '0;
            pcnt   <= '0;
            mode_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state  <= ST_CONV;
                        tcnt   <= '0;
                        pcnt   <= '0;
                        mode_q <= rise_mode_i;
                        err_q  <= 1'b0;
                    end
                end
                ST_CONV: begin
                    tcnt <= tcnt + 1'b1;
                    if (tcnt == TW'(CONV_LOW - 1)) state <= ST_WLO;
                end
                ST_WLO: begin
                    tcnt <= tcnt + 1'b1;
                    if (tmo) begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                    end else if (!busy_i) begin
                        state <= ST_WHI;
                    end
                end
                ST_WHI: begin
                    tcnt <= tcnt + 1'b1;
                    if (tmo) begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                    end else if (busy_i) begin
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (rise) pcnt <= pcnt + 1'b1;
                    if (fall && (pcnt == total)) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    conv_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_n_o) |-> ($past(state) == ST_IDLE) && $past(start_i));
    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> !$fell(conv_n_o));
    // R3
    quiet_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_CONV, ST_WLO, ST_WHI}) |-> !sclk_o);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R8
    done_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !sclk_o);
    // R10
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> ($past(state) == ST_WLO) || ($past(state) == ST_WHI));
endmodule

// File: tb/sar_read_ctrl_bench.sv
// Directed bench: converter model with busy handshake and serial data
// that moves just after each sclk rising edge.
module sar_read_ctrl_bench;
    localparam int WW  = 16;
    localparam int DEV = 2;
    localparam int HD  = 2;
    localparam int CL  = 3;
    localparam int TO  = 300;
    localparam int BUSY_CYC = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic rise_mode_i = 1'b0;
    logic busy_i = 1'b1;
    logic sdata_i = 1'b0;
    logic conv_n_o, cs_n_o, sclk_o, word_valid_o, done_o, err_o, idle_o;
    logic [WW-1:0] word_o;
    logic [0:0] word_idx_o;

    always #10 clk = ~clk;

    sar_read_ctrl #(.WORD_W(WW), .DEVICES(DEV), .HALF_DIV(HD),
                    .CONV_LOW(CL), .TIMEOUT(TO)) u_sar_read_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rise_mode_i(rise_mode_i),
        .busy_i(busy_i), .sdata_i(sdata_i), .conv_n_o(conv_n_o), .cs_n_o(cs_n_o),
        .sclk_o(sclk_o), .word_o(word_o), .word_idx_o(word_idx_o),
        .word_valid_o(word_valid_o), .done_o(done_o), .err_o(err_o), .idle_o(idle_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    // converter model state (stream and stuck written only by the main process)
    logic [2*WW-1:0] stream = '0;
    logic stuck = 1'b0;
    int bitpos = 0;
    int bcnt = 0;

    // Serial data: moves 2 ns after each rising edge, tag ones after the words.
    always @(posedge sclk_o or negedge conv_n_o) begin
        if (!conv_n_o) bitpos <= 0;
        else begin
            sdata_i <= #2 (bitpos < 2*WW) ? stream[2*WW-1-bitpos] : 1'b1;
            bitpos <= bitpos + 1;
        end
    end

    // Busy: falls on the start strobe, rises BUSY_CYC cycles later unless stuck.
    always @(negedge clk) begin
        if (bcnt != 0) begin
            bcnt <= bcnt - 1;
            if (bcnt == 1) busy_i <= 1'b1;
        end else if (!conv_n_o) begin
            busy_i <= 1'b0;
            bcnt <= stuck ? 0 : BUSY_CYC;
        end else if (!stuck) begin
            busy_i <= 1'b1;
        end
    end

    // Monitors, sampled on the falling system-clock edge.
    int cyc = 0, n_rise = 0, n_quiet = 0, n_badw = 0, hw = 0;
    int n_conv = 0, clw = 0, last_clw = 0, n_done = 0, rise_at_done = 0;
    int n_words = 0, t_conv = 0, t_err = 0, sclk_at_done = 0;
    logic sclk_p = 1'b0, conv_p = 1'b1, err_p = 1'b0;
    logic [WW-1:0] words [0:DEV-1];

    always @(negedge clk) begin
        if (sclk_o && !sclk_p) begin
            n_rise <= n_rise + 1;
            if (!busy_i) n_quiet <= n_quiet + 1;
            hw <= 1;
        end else if (sclk_o) hw <= hw + 1;
        if (!sclk_o && sclk_p && hw != HD) n_badw <= n_badw + 1;
        if (!conv_n_o && conv_p) begin
            n_conv <= n_conv + 1;
            t_conv <= cyc;
            clw <= 1;
        end else if (!conv_n_o) clw <= clw + 1;
        if (conv_n_o && !conv_p) last_clw <= clw;
        if (done_o) begin
            n_done <= n_done + 1;
            rise_at_done <= n_rise;
            sclk_at_done <= int'(sclk_o);
        end
        if (word_valid_o) begin
            words[word_idx_o] <= word_o;
            n_words <= n_words + 1;
        end
        if (err_o && !err_p) t_err <= cyc;
        sclk_p <= sclk_o;
        conv_p <= conv_n_o;
        err_p <= err_o;
        cyc <= cyc + 1;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    // R1: reset values and chip select.
    task automatic t_reset();
        @(negedge clk);
        chk("R1 conv_n", conv_n_o, 1);
        chk("R1 sclk", sclk_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 err", err_o, 0);
        chk("R1 valid", word_valid_o, 0);
        chk("R1 idle", idle_o, 1);
        chk("R1 cs_n", cs_n_o, 0);
    endtask

    // One full read; poke adds a second start and a mode flip mid-flight.
    task automatic t_read(input logic mode, input logic [WW-1:0] w0,
                          input logic [WW-1:0] w1, input bit poke);
        int r0, q0, b0, c0, d0, k0;
        stream = {w0, w1};
        rise_mode_i = mode;
        r0 = n_rise; q0 = n_quiet; b0 = n_badw; c0 = n_conv; d0 = n_done; k0 = n_words;
        pulse_start();
        if (poke) begin
            rise_mode_i = ~mode;       // R11: must not change this burst
            repeat (10) @(negedge clk);
            pulse_start();             // R9: ignored during the wait
            while (n_rise < r0 + 5) @(negedge clk);
            pulse_start();             // R9: ignored during the burst
        end
        while (n_done == d0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R2 conv low width", last_clw, CL);
        chk("R9 single conv strobe", n_conv - c0, 1);
        chk("R3 pulses while busy low", n_quiet - q0, 0);
        chk("R4/R11 pulse count", n_rise - r0, DEV*WW + (mode ? 1 : 0));
        chk("R4 high width errors", n_badw - b0, 0);
        chk(mode ? "R5 word0" : "R6 word0", words[0], w0);
        chk(mode ? "R5 word1" : "R6 word1", words[1], w1);
        chk("R7 word count", n_words - k0, DEV);
        chk("R8 done count", n_done - d0, 1);
        chk("R8 pulses before done", rise_at_done - r0, DEV*WW + (mode ? 1 : 0));
        chk("R8 sclk low at done", sclk_at_done, 0);
        chk("R10 err clear", err_o, 0);
        chk("R9 back to idle", idle_o, 1);
    endtask

    // R10: busy held low forces the timeout.
    task automatic t_timeout();
        int r0;
        r0 = n_rise;
        stuck = 1'b1;
        rise_mode_i = 1'b1;
        pulse_start();
        repeat (TO + 20) @(negedge clk);
        chk("R10 err raised", err_o, 1);
        chk("R10 timeout cycles", t_err - t_conv, TO);
        chk("R10 no burst", n_rise - r0, 0);
        chk("R10 idle", idle_o, 1);
        stuck = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read(1'b1, 16'hA5C3, 16'h3C5A, 1'b0);
        t_read(1'b0, 16'h8001, 16'h7FFE, 1'b0);
        t_read(1'b1, 16'hFFFF, 16'h0000, 1'b1);
        t_read(1'b0, 16'h1234, 16'hFEDC, 1'b1);
        t_timeout();
        t_read(1'b1, 16'h0F0F, 16'hC001, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule